// File: doc/BRIEF.md
# Supply Supervisor Write-Protect Sequencer

This block watches two digitised supply comparator flags. One says the supply is under the level where writes stop being safe. The other says the supply is under the lower level where the part must run from its backup cell. From these flags it drives four outputs: a write-block line, a one-cycle abort strobe, a backup-cell select and a low-power request. The abort strobe and write-block line go to the serial slave. The strobe makes the slave drop the transfer in flight and clear its address pointer. The write-block line keeps the slave from acting on any bus input.

Both flags pass through a two-flop synchroniser before the controller sees them. A raised lower-level flag is taken to mean the upper-level flag is raised as well. After the supply comes back, the block keeps writes blocked for a recovery window of `REC_CYCLES` system-clock cycles. Any new dip during that window sends the block back to the protected state, and the full window starts over. The block leaves reset in the protected state, so nothing can be written until one full recovery window has passed with a good supply.

Top module: `pfg_supervisor`

## Requirements
- R1: While reset is held, and after reset until the recovery window has run, wr_block_o is 1 and abort_pulse_o, batt_sel_o and lowpwr_o are 0.
- R2: Each raw flag passes through two synchroniser flops. The outputs respond on the third rising clock edge after a raw flag changes, and not on an earlier edge.
- R3: If either flag rises while writes are enabled, wr_block_o goes to 1. In that same cycle abort_pulse_o is 1 for exactly one cycle.
- R4: A raised backup-level flag sets batt_sel_o and lowpwr_o to 1 and blocks writes, even when the upper-level flag is 0.
- R5: When the backup-level flag falls, batt_sel_o and lowpwr_o return to 0 and wr_block_o stays 1.
- R6: After both synchronised flags read 0, wr_block_o stays 1 for exactly REC_CYCLES cycles and then drops to 0.
- R7: A flag that rises during the recovery window puts the block back into protection and restarts the full window. No abort pulse is issued for it.
- R8: A flag that becomes visible in the same cycle the recovery count expires takes priority. wr_block_o does not drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_pf_raw_i | input | 1 | Raw flag: supply under the write-safe level |
| below_so_raw_i | input | 1 | Raw flag: supply under the backup switchover level |
| wr_block_o | output | 1 | 1 while bus writes and inputs are to be ignored |
| abort_pulse_o | output | 1 | One-cycle strobe to abort the access and clear the address pointer |
| batt_sel_o | output | 1 | 1 selects the backup cell as supply |
| lowpwr_o | output | 1 | 1 requests the ultra-low-current mode |

## Verification
Two events can land on the same clock edge. One is the expiry of the recovery count, which would release protection. The other is a fresh supply dip, which must hold protection. The bench provokes this by raising the raw upper-level flag exactly REC_CYCLES edges after releasing it, so that its synchronised copy arrives on the edge where the count reaches zero. The test passes only if wr_block_o stays 1, no abort strobe appears, and a complete new window is then needed before release.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_PROTECTED = 2'd1,
        ST_BATTERY   = 2'd2,
        ST_RECOVER   = 2'd3
    } pfg_state_e;

    localparam int unsigned FLAG_PF = 0;
    localparam int unsigned FLAG_SO = 1;
    localparam int unsigned N_FLAGS = 2;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int unsigned         WIDTH   = 2,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q[g] <= RST_VAL;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pf_i,
    input  logic so_i,
    output logic wr_block_o,
    output logic abort_o,
    output logic batt_o
);

    localparam int unsigned CW   = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(REC_CYCLES - 1);

    typedef struct packed {
        pfg_state_e    state;
        logic [CW-1:0] cnt;
        logic          abort;
    } regs_t;

    regs_t r_d, r_q;
    logic  low_any;

    assign low_any = pf_i | so_i;

    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        unique case (r_q.state)
            ST_NORMAL: begin
                if (so_i) begin
                    r_d.state = ST_BATTERY;
                    r_d.abort = 1'b1;
                end else if (low_any) begin
                    r_d.state = ST_PROTECTED;
                    r_d.abort = 1'b1;
                end
            end
            ST_PROTECTED: begin
                if (so_i) begin
                    r_d.state = ST_BATTERY;
                end else if (!low_any) begin
                    r_d.state = ST_RECOVER;
                    r_d.cnt   = LOAD;
                end
            end
            ST_BATTERY: begin
                if (!so_i) begin
                    if (low_any) begin
                        r_d.state = ST_PROTECTED;
                    end else begin
                        r_d.state = ST_RECOVER;
                        r_d.cnt   = LOAD;
                    end
                end
            end
            ST_RECOVER: begin
                if (so_i) begin
                    r_d.state = ST_BATTERY;
                end else if (low_any) begin
                    r_d.state = ST_PROTECTED;
                end else if (r_q.cnt == '0) begin
                    r_d.state = ST_NORMAL;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = ST_PROTECTED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_PROTECTED;
            r_q.cnt   <= '0;
            r_q.abort <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_block_o = (r_q.state != ST_NORMAL);
    assign batt_o     = (r_q.state == ST_BATTERY);
    assign abort_o    = r_q.abort;

    // R3
    fail_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_NORMAL && low_any) |=> (wr_block_o && abort_o));

    // R3
    abort_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |=> !abort_o);

    // R4
    batt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        so_i |=> batt_o);

    // R6
    release_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wr_block_o) |-> $past(r_q.state == ST_RECOVER && r_q.cnt == '0));

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cnt < REC_CYCLES);

    // R7
    redip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RECOVER && pf_i && !so_i) |=> (r_q.state == ST_PROTECTED && !abort_o));

endmodule

// File: rtl/pfg_supervisor.sv
module pfg_supervisor
    import pfg_pkg::*;
#(
    parameter int unsigned REC_CYCLES  = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic below_pf_raw_i,
    input  logic below_so_raw_i,
    output logic wr_block_o,
    output logic abort_pulse_o,
    output logic batt_sel_o,
    output logic lowpwr_o
);

    localparam logic [N_FLAGS-1:0] SYNC_RST = N_FLAGS'(1) << FLAG_PF;

    logic [N_FLAGS-1:0] raw_flags;
    logic [N_FLAGS-1:0] sync_flags;
    logic               batt;

    assign raw_flags[FLAG_PF] = below_pf_raw_i;
    assign raw_flags[FLAG_SO] = below_so_raw_i;

    pfg_sync #(
        .WIDTH   (N_FLAGS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (raw_flags),
        .dout_o (sync_flags)
    );

    pfg_fsm #(
        .REC_CYCLES (REC_CYCLES)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pf_i       (sync_flags[FLAG_PF]),
        .so_i       (sync_flags[FLAG_SO]),
        .wr_block_o (wr_block_o),
        .abort_o    (abort_pulse_o),
        .batt_o     (batt)
    );

    assign batt_sel_o = batt;
    assign lowpwr_o   = batt;

    // R1
    rst_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (wr_block_o && !abort_pulse_o && !batt_sel_o));

endmodule

// File: tb/pfg_supervisor_test.sv
module pfg_supervisor_test;

    localparam int unsigned REC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_raw = 1'b0;
    logic so_raw = 1'b0;
    logic wr_block, abort_p, batt_sel, lowpwr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfg_supervisor #(.REC_CYCLES(REC), .SYNC_STAGES(2)) uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .below_pf_raw_i (pf_raw),
        .below_so_raw_i (so_raw),
        .wr_block_o     (wr_block),
        .abort_pulse_o  (abort_p),
        .batt_sel_o     (batt_sel),
        .lowpwr_o       (lowpwr)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_normal();
        pf_raw = 1'b0;
        so_raw = 1'b0;
        adv(3 + REC);
        chk("R6 reach normal", wr_block, 1'b0);
    endtask

    task automatic t_reset();
        adv(2);
        chk("R1 block in reset", wr_block, 1'b1);
        chk("R1 no abort in reset", abort_p, 1'b0);
        chk("R1 no batt in reset", batt_sel, 1'b0);
        chk("R1 no lowpwr in reset", lowpwr, 1'b0);
        rst_n = 1'b1;
        adv(2 + REC);
        chk("R1 still blocked before window end", wr_block, 1'b1);
        chk("R1 no abort after reset", abort_p, 1'b0);
        adv(1);
        chk("R6 release after reset window", wr_block, 1'b0);
    endtask

    task automatic t_pf_latency();
        pf_raw = 1'b1;
        adv(2);
        chk("R2 no response on second edge", wr_block, 1'b0);
        chk("R2 no early abort", abort_p, 1'b0);
        adv(1);
        chk("R3 block on third edge", wr_block, 1'b1);
        chk("R3 abort strobe", abort_p, 1'b1);
        chk("R3 no batt on pf", batt_sel, 1'b0);
        adv(1);
        chk("R3 abort one cycle", abort_p, 1'b0);
        chk("R3 block held", wr_block, 1'b1);
        pf_raw = 1'b0;
        adv(2 + REC);
        chk("R6 held REC cycles", wr_block, 1'b1);
        adv(1);
        chk("R6 released", wr_block, 1'b0);
    endtask

    task automatic t_battery();
        pf_raw = 1'b1;
        so_raw = 1'b1;
        adv(3);
        chk("R4 batt_sel", batt_sel, 1'b1);
        chk("R4 lowpwr", lowpwr, 1'b1);
        chk("R4 block", wr_block, 1'b1);
        chk("R3 abort on battery entry", abort_p, 1'b1);
        so_raw = 1'b0;
        adv(3);
        chk("R5 batt off", batt_sel, 1'b0);
        chk("R5 lowpwr off", lowpwr, 1'b0);
        chk("R5 block kept", wr_block, 1'b1);
        adv(REC + 5);
        chk("R5 block held under pf", wr_block, 1'b1);
        go_normal();
    endtask

    task automatic t_so_only();
        so_raw = 1'b1;
        adv(3);
        chk("R4 so alone selects batt", batt_sel, 1'b1);
        chk("R4 so alone blocks", wr_block, 1'b1);
        chk("R4 so alone aborts", abort_p, 1'b1);
        so_raw = 1'b0;
        adv(3);
        chk("R5 batt off direct", batt_sel, 1'b0);
        chk("R5 still blocked", wr_block, 1'b1);
        adv(REC - 1);
        chk("R6 held from battery", wr_block, 1'b1);
        adv(1);
        chk("R6 release from battery", wr_block, 1'b0);
    endtask

    task automatic t_recover_restart();
        pf_raw = 1'b1;
        adv(3);
        pf_raw = 1'b0;
        adv(7);
        chk("R7 in window", wr_block, 1'b1);
        pf_raw = 1'b1;
        adv(3);
        chk("R7 blocked after redip", wr_block, 1'b1);
        chk("R7 no abort on redip", abort_p, 1'b0);
        pf_raw = 1'b0;
        adv(2 + REC);
        chk("R7 full window restarted", wr_block, 1'b1);
        adv(1);
        chk("R7 release after restart", wr_block, 1'b0);
    endtask

    task automatic t_coincide();
        pf_raw = 1'b1;
        adv(3);
        pf_raw = 1'b0;
        adv(REC);
        pf_raw = 1'b1;
        adv(2);
        chk("R8 pre-expiry blocked", wr_block, 1'b1);
        adv(1);
        chk("R8 dip wins at expiry", wr_block, 1'b1);
        chk("R8 no abort at expiry", abort_p, 1'b0);
        adv(1);
        chk("R8 stays blocked", wr_block, 1'b1);
        pf_raw = 1'b0;
        adv(2 + REC);
        chk("R8 new window held", wr_block, 1'b1);
        adv(1);
        chk("R8 release after new window", wr_block, 1'b0);
    endtask

    initial begin
        adv(1);
        t_reset();
        t_pf_latency();
        t_battery();
        t_so_only();
        t_recover_restart();
        t_coincide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule